// File: doc/BRIEF.md
# Branch History Table on Synchronous RAM

A direct-mapped table of branch outcome predictors. Each row holds a valid flag and a two-bit saturating counter. The rows live in a synchronous RAM with two read ports and one write port. One read port serves the fetch-side lookup. The other read port serves the read-modify-write that folds resolved branch outcomes back into the table.

The fetch side presents its program counter one cycle early, so the registered RAM read lines up with the cycle in which the prediction is used. An update takes three steps: read the old row, compute the new row, write it back. Between the update and the moment the RAM can return the new row there is a gap of two cycles. A staged bypass fills that gap. The freshly computed row is used one cycle after the update. A holding register supplies the row two cycles after the update. From the third cycle on, the RAM itself supplies it. The same holding register also feeds the next read-modify-write when two updates to one row arrive back to back.

Target address prediction is not part of this block.

Top module: `branch_hist_table`

## Requirements
- R1: After reset every row is invalid. Until a row is updated, a lookup of it gives predValid=0 and predTaken=0.
- R2: A lookup PC presented in cycle c is answered in cycle c+1. The row index is lookPcEarly[ROW_OFS +: IDX_W], which is bits 7:2 by default. All other PC bits are ignored, and updPc is indexed the same way.
- R3: An update starts from the row's current counter, or from 1 if the row is invalid. It adds 1 when updTaken=1 and subtracts 1 when updTaken=0, saturating at 0 and 3, and it sets the row valid.
- R4: predValid is the row's valid flag. predTaken is 1 exactly when the row is valid and its counter is 2 or 3. predTaken is never 1 while predValid is 0.
- R5: The prediction in cycle c reflects every update presented in cycles up to and including c-1. This holds whether the update is 1, 2 or 3 or more cycles old.
- R6: Updates to the same row in consecutive cycles, or two cycles apart, all accumulate. No update is lost.
- R7: An update to one row never changes the prediction given for a different row.
- R8: A cycle with updValid=0 changes no row, whatever updPc and updTaken hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookPcEarly | input | PC_W | Fetch PC, one cycle ahead of use |
| predValid | output | 1 | Row of last cycle's lookup is valid |
| predTaken | output | 1 | Prediction for last cycle's lookup is taken |
| updValid | input | 1 | Resolved-branch update strobe |
| updPc | input | PC_W | PC of the resolved branch |
| updTaken | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench reads the row that was updated exactly one, two and three cycles earlier, so each source of the prediction mux is exercised on its own. A wrong age in the select logic would show up as a stale, not-yet-valid prediction. It then updates one row in consecutive cycles and in cycles two apart. A design without the holding-register forwarding into the read-modify-write would lose one step of the counter. Saturation runs in both directions catch counters that wrap. Lookups of aliasing PCs and of neighbouring rows, made while an update is in flight, catch a bypass that ignores the index compare.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef struct packed {
    logic       valid;
    logic [1:0] ctr;
  } bhtEntry_t;

  localparam int ENTRY_W = $bits(bhtEntry_t);

  typedef enum logic [1:0] {SRC_RAM, SRC_UPD, SRC_AUX} predSrc_t;

  // control -> datapath strobes
  typedef struct packed {
    logic     wrEn;
    logic     auxLoad;
    logic     rmwFromAux;
    predSrc_t predSrc;
  } bhtStrobe_t;

  // datapath -> control index comparisons
  typedef struct packed {
    logic lookHitUpd;
    logic lookHitAux;
    logic updHitAux;
  } bhtMatch_t;

  function automatic bhtEntry_t bumpEntry(bhtEntry_t cur, logic taken);
    logic [1:0] base;
    bhtEntry_t  nxt;
    base      = cur.valid ? cur.ctr : 2'd1;
    nxt.valid = 1'b1;
    if (taken) nxt.ctr = (base == 2'd3) ? 2'd3 : base + 2'd1;
    else       nxt.ctr = (base == 2'd0) ? 2'd0 : base - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bht_ram.sv
module bht_ram #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdAddr0,
  output logic [DATA_W-1:0] rdData0,
  input  logic [IDX_W-1:0]  rdAddr1,
  output logic [DATA_W-1:0] rdData1,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-during-write returns the old row on both read ports.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdData0 <= '0;
      rdData1 <= '0;
    end else begin
      rdData0 <= mem[rdAddr0];
      rdData1 <= mem[rdAddr1];
      if (wrEn) mem[wrAddr] <= wrData;
    end
  end
endmodule

// File: rtl/bht_ctrl.sv
module bht_ctrl
  import bht_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updValid,
  input  bhtMatch_t  match,
  output bhtStrobe_t strobe
);
  logic s1Valid;   // update one cycle old, row data now out of RAM
  logic auxValid;  // update two cycles old, row held in aux buffer

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      auxValid <= 1'b0;
    end else begin
      s1Valid  <= updValid;
      auxValid <= s1Valid;
    end
  end

  always_comb begin
    strobe.wrEn       = s1Valid;
    strobe.auxLoad    = s1Valid;
    strobe.rmwFromAux = auxValid && match.updHitAux;
    if (s1Valid && match.lookHitUpd)      strobe.predSrc = SRC_UPD;
    else if (auxValid && match.lookHitAux) strobe.predSrc = SRC_AUX;
    else                                   strobe.predSrc = SRC_RAM;
  end
endmodule

// File: rtl/bht_dp.sv
module bht_dp
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int ROW_OFS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PC_W-1:0]    lookPcEarly,
  input  logic [PC_W-1:0]    updPc,
  input  logic               updTaken,
  input  bhtStrobe_t         strobe,
  input  logic [ENTRY_W-1:0] rdData0,
  input  logic [ENTRY_W-1:0] rdData1,
  output logic [IDX_W-1:0]   rdAddr0,
  output logic [IDX_W-1:0]   rdAddr1,
  output logic [IDX_W-1:0]   wrAddr,
  output logic [ENTRY_W-1:0] wrData,
  output bhtMatch_t          match,
  output logic               predValid,
  output logic               predTaken
);
  logic [IDX_W-1:0] lookIdxQ, s1Idx, auxIdx;
  logic             s1Taken;
  bhtEntry_t        auxEntry, oldEntry, newEntry, predEntry;

  assign rdAddr0 = lookPcEarly[ROW_OFS +: IDX_W];
  assign rdAddr1 = updPc[ROW_OFS +: IDX_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lookIdxQ <= '0;
      s1Idx    <= '0;
      s1Taken  <= 1'b0;
      auxIdx   <= '0;
      auxEntry <= '0;
    end else begin
      lookIdxQ <= rdAddr0;
      s1Idx    <= rdAddr1;
      s1Taken  <= updTaken;
      if (strobe.auxLoad) begin
        auxIdx   <= s1Idx;
        auxEntry <= newEntry;
      end
    end
  end

  // read-modify-write: forward the row still in flight to the RAM
  assign oldEntry = strobe.rmwFromAux ? auxEntry : bhtEntry_t'(rdData1);
  assign newEntry = bumpEntry(oldEntry, s1Taken);
  assign wrAddr   = s1Idx;
  assign wrData   = newEntry;

  assign match.lookHitUpd = (lookIdxQ == s1Idx);
  assign match.lookHitAux = (lookIdxQ == auxIdx);
  assign match.updHitAux  = (s1Idx == auxIdx);

  always_comb begin
    unique case (strobe.predSrc)
      SRC_UPD: predEntry = newEntry;
      SRC_AUX: predEntry = auxEntry;
      default: predEntry = bhtEntry_t'(rdData0);
    endcase
  end

  assign predValid = predEntry.valid;
  assign predTaken = predEntry.valid && predEntry.ctr[1];
endmodule

// File: rtl/branch_hist_table.sv
module branch_hist_table
  import bht_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int ROW_OFS = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookPcEarly,
  output logic            predValid,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);
  bhtStrobe_t         strobe;
  bhtMatch_t          match;
  logic [IDX_W-1:0]   rdAddr0, rdAddr1, wrAddr;
  logic [ENTRY_W-1:0] rdData0, rdData1, wrData;

  bht_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .updValid(updValid), .match(match), .strobe(strobe)
  );

  bht_dp #(.PC_W(PC_W), .IDX_W(IDX_W), .ROW_OFS(ROW_OFS)) dp_i (
    .clk(clk), .rstN(rstN), .lookPcEarly(lookPcEarly), .updPc(updPc),
    .updTaken(updTaken), .strobe(strobe), .rdData0(rdData0), .rdData1(rdData1),
    .rdAddr0(rdAddr0), .rdAddr1(rdAddr1), .wrAddr(wrAddr), .wrData(wrData),
    .match(match), .predValid(predValid), .predTaken(predTaken)
  );

  bht_ram #(.IDX_W(IDX_W), .DATA_W(ENTRY_W)) ram_i (
    .clk(clk), .rstN(rstN), .rdAddr0(rdAddr0), .rdData0(rdData0),
    .rdAddr1(rdAddr1), .rdData1(rdData1), .wrEn(strobe.wrEn),
    .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int ROW_OFS = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookPcEarly,
  input logic            predValid,
  input logic            predTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input logic            wrEn
);
  logic [IDX_W-1:0] lookIdx, updIdx;
  assign lookIdx = lookPcEarly[ROW_OFS +: IDX_W];
  assign updIdx  = updPc[ROW_OFS +: IDX_W];

  // R4: taken only on a valid row
  a_r4_taken_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predValid);

  // R5: an update is visible to a matching lookup in the very next cycle
  a_r5_visible_next: assert property (@(posedge clk) disable iff (!rstN)
    updValid && (updIdx == lookIdx) |=> predValid);

  // R5: a RAM write follows each update by exactly one cycle
  a_r5_write_follows_update: assert property (@(posedge clk) disable iff (!rstN)
    wrEn == $past(updValid));

  // R6: two taken updates in a row to one row leave it predicting taken
  a_r6_two_taken: assert property (@(posedge clk) disable iff (!rstN)
    $past(updValid, 2) && $past(updTaken, 2) && $past(updValid) && $past(updTaken) &&
    ($past(updIdx, 2) == $past(updIdx)) && ($past(lookIdx) == $past(updIdx))
    |-> predTaken);

  // R6: two not-taken updates in a row leave it predicting not taken
  a_r6_two_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    $past(updValid, 2) && !$past(updTaken, 2) && $past(updValid) && !$past(updTaken) &&
    ($past(updIdx, 2) == $past(updIdx)) && ($past(lookIdx) == $past(updIdx))
    |-> predValid && !predTaken);
endmodule

bind branch_hist_table bht_checker #(.PC_W(PC_W), .IDX_W(IDX_W), .ROW_OFS(ROW_OFS)) chk_i (
  .clk(clk), .rstN(rstN), .lookPcEarly(lookPcEarly), .predValid(predValid),
  .predTaken(predTaken), .updValid(updValid), .updPc(updPc), .updTaken(updTaken),
  .wrEn(strobe.wrEn)
);

// File: tb/branch_hist_table_tb_top.sv
`timescale 1ns/1ps
module branch_hist_table_tb_top;
  localparam int PC_W = 32, IDX_W = 6, ROW_OFS = 2, ROWS = 1 << IDX_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic [PC_W-1:0] lookPc = '0, updPc = '0;
  logic updValid = 1'b0, updTaken = 1'b0;
  logic predValid, predTaken;

  int checks = 0, fails = 0;
  bit vM[ROWS];
  int cM[ROWS];

  always #2 clk = ~clk;

  branch_hist_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ROW_OFS(ROW_OFS)) dut_i (
    .clk(clk), .rstN(rstN), .lookPcEarly(lookPc), .predValid(predValid),
    .predTaken(predTaken), .updValid(updValid), .updPc(updPc), .updTaken(updTaken)
  );

  function automatic int ix(logic [PC_W-1:0] pc);
    return int'(pc[ROW_OFS +: IDX_W]);
  endfunction

  task automatic check(string tag, logic av, logic at, logic ev, logic et);
    checks++;
    if (av !== ev || at !== et) begin
      fails++;
      $display("FAIL %s: got valid=%0b taken=%0b expected valid=%0b taken=%0b",
               tag, av, at, ev, et);
    end
  endtask

  // Called at a negedge: drive, clock, advance model, sample at next negedge.
  task automatic step(logic [PC_W-1:0] lp, logic uv, logic [PC_W-1:0] up, logic ut, string tag);
    int base, r;
    logic ev, et;
    lookPc = lp; updValid = uv; updPc = up; updTaken = ut;
    @(posedge clk);
    if (uv) begin
      r = ix(up);
      base = vM[r] ? cM[r] : 1;
      cM[r] = ut ? ((base == 3) ? 3 : base + 1) : ((base == 0) ? 0 : base - 1);
      vM[r] = 1'b1;
    end
    ev = vM[ix(lp)];
    et = ev && (cM[ix(lp)] >= 2);
    @(negedge clk);
    check(tag, predValid, predTaken, ev, et);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] a, b, c, d;
    for (int i = 0; i < ROWS; i++) begin vM[i] = 1'b0; cM[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: nothing valid after reset
    for (int i = 0; i < 8; i++) step(32'h1000_0000 * i + 32'h4 * i, 1'b0, '0, 1'b0, "R1 reset");

    // R5: ages 1, 2, 3 of one update
    a = 32'h0000_0014;
    step(a, 1'b1, a, 1'b1, "R5 age1");
    step(a, 1'b0, '0, 1'b0, "R5 age2");
    step(a, 1'b0, '0, 1'b0, "R5 age3");
    b = 32'h0000_0040;
    step(a, 1'b1, b, 1'b1, "R7 other row");
    step(b, 1'b0, '0, 1'b0, "R5 age2 only");
    c = 32'h0000_0080;
    step(a, 1'b1, c, 1'b0, "R7 other row");
    step(a, 1'b0, '0, 1'b0, "R5 idle");
    step(c, 1'b0, '0, 1'b0, "R5 age3 only");

    // R6: back-to-back and gap-two updates to one row
    d = 32'h0000_00F0;
    step(d, 1'b1, d, 1'b1, "R6 b2b");
    step(d, 1'b1, d, 1'b1, "R6 b2b");
    step(d, 1'b1, d, 1'b0, "R6 b2b");
    step(d, 1'b0, '0, 1'b0, "R6 b2b settle");
    step(d, 1'b0, '0, 1'b0, "R6 b2b settle");
    step(d, 1'b1, d, 1'b0, "R6 gap2");
    step(a, 1'b0, '0, 1'b0, "R6 gap2");
    step(d, 1'b1, d, 1'b0, "R6 gap2");
    step(a, 1'b0, '0, 1'b0, "R6 gap2");
    step(d, 1'b0, '0, 1'b0, "R6 gap2 result");

    // R3: saturation at 3 and at 0
    for (int i = 0; i < 6; i++) step(b, 1'b1, b, 1'b1, "R3 saturate up");
    step(b, 1'b0, '0, 1'b0, "R3 hold at 3");
    step(b, 1'b1, b, 1'b0, "R3 down from 3");
    for (int i = 0; i < 6; i++) step(b, 1'b1, b, 1'b0, "R3 saturate down");
    step(b, 1'b1, b, 1'b1, "R3 up from 0");

    // R2: aliasing PCs and ignored low bits
    step(32'hABCD_0017, 1'b1, 32'h1234_0014, 1'b1, "R2 alias");
    step(32'h0000_0016, 1'b0, '0, 1'b0, "R2 low bits");
    step(32'h0000_0018, 1'b0, '0, 1'b0, "R2 neighbour R7");

    // R8: disabled updates change nothing
    for (int i = 0; i < 6; i++) step(a, 1'b0, a, i[0], "R8 no update");
    step(d, 1'b0, d, 1'b1, "R8 no update");

    // R4 R5 R6 R7: random stream over few rows
    for (int i = 0; i < 3000; i++)
      step(($urandom & 32'hFFFF_FF03) | ($urandom & 32'h0000_001C), 1'($urandom),
           ($urandom & 32'hFFFF_FF03) | ($urandom & 32'h0000_001C), 1'($urandom),
           "R4 random");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule